// File: doc/BRIEF.md
# Mesh Router Switch Allocator with Retained Virtual Channels

This block decides, once per cycle, which flits in a five-port mesh router cross the switch. It works in two separable arbitration rounds. In the first round, each input port picks one of its virtual channels that has an eligible request. In the second round, each output port picks one of the inputs whose first-round winner targets it. The input winner drives the input multiplexer select and the output winner drives the output multiplexer select.

A packet never changes virtual channel in the network. Because of this, channel allocation is reduced to one step: after the output round, the winning head flit claims the channel with its own index at the output it won. This claim is not speculative, because a head flit only requests an output where its own channel is idle downstream and not already held. Adaptive routing comes from the congestion flags: a congested output is removed from a head flit's set of admissible minimal outputs before it picks a target. Body and tail flits follow the output that their head flit took.

Flit storage, the crossbar data path and credit counting sit outside this block. They supply the request vectors and the downstream idle status, and they consume the grant and ownership signals.

Top module: `switch_alloc_rvc`

## Requirements
- R1: After reset no output channel is owned and both round-robin pointers of every arbiter start at index 0, so the lowest-numbered requesting VC and input win first.
- R2: A head flit of VC v requests output o only when `out_vc_idle[o*NUM_VC+v]` is 1 and channel (o,v) is not owned; otherwise that output gives it no grant.
- R3: For a head flit, the candidate outputs are its route bits (bit `(k*5+o)` for input VC k = i*NUM_VC+v) with congested outputs removed, or all route bits if every one is congested. It targets the lowest-numbered candidate whose channel is free.
- R4: The first round is round-robin among the eligible VCs of an input. After VC v of input i is granted, priority starts at v+1.
- R5: The second round is round-robin among requesting inputs per output. After input i is granted, priority starts at i+1.
- R6: Each output grants at most one input and each granted input receives exactly one output, so the count of `out_gnt` bits equals the count of `in_gnt` bits. Bit `o*5+i` of `out_gnt` means output o serves input i.
- R7: A granted head flit of VC v pulses `vc_claim[o*NUM_VC+v]` for the output o it won, with the same channel index, and that channel reads owned from the next cycle on.
- R8: A granted tail flit pulses `vc_release` for its channel, which reads free from the next cycle on. A single-flit packet (head and tail together) leaves the channel free.
- R9: Body and tail flits request only the output held by their head flit, whatever their route bits, congestion flags or downstream idle status.
- R10: An arbiter pointer moves only on a grant. A first-round winner that loses at the output leaves its input pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 5*NUM_VC | Flit waiting at input VC k = i*NUM_VC+v |
| req_head | input | 5*NUM_VC | Waiting flit is a head flit |
| req_tail | input | 5*NUM_VC | Waiting flit is a tail flit |
| req_route | input | 5*NUM_VC*5 | Admissible minimal outputs per input VC, bit k*5+o |
| out_vc_idle | input | 5*NUM_VC | Downstream channel idle, bit o*NUM_VC+v |
| out_congested | input | 5 | Congestion flag per output |
| in_gnt | output | 1*5 | Input i is granted this cycle |
| in_gnt_vc | output | 5*log2(NUM_VC) | Granted VC index per input |
| in_gnt_out | output | 5*3 | Granted output index per input |
| out_gnt | output | 25 | One-hot input selection per output, bit o*5+i |
| vc_claim | output | 5*NUM_VC | Channel (o,v) taken by a head flit this cycle |
| vc_release | output | 5*NUM_VC | Channel (o,v) freed by a tail flit this cycle |
| vc_owned | output | 5*NUM_VC | Registered ownership of each output channel |

## Verification
The bench targets the case where a first-round winner loses at the output while another VC of the same input waits. A design that advances the input pointer regardless would serve the other VC next and violate R10. It also holds a downstream channel busy and then owned. A design that ignores either condition would grant twice into one channel. Further cases check that body flits still reach their held output when that output is congested, not idle downstream, and absent from their route bits; a design that re-routed body flits would split a packet. Single-flit packets and multi-flit packets are run side by side. A design that mishandles the simultaneous claim and release would leave a channel locked forever.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int PORTS   = 5;
  localparam int PORT_IW = $clog2(PORTS);

  typedef logic [PORTS-1:0]   port_vec_t;
  typedef logic [PORT_IW-1:0] port_idx_t;

  // keep only the lowest set bit of a port vector
  function automatic port_vec_t lowest_bit(input port_vec_t v);
    return v & (~v + port_vec_t'(1));
  endfunction

  // index of a one-hot port vector (0 when empty)
  function automatic port_idx_t port_index(input port_vec_t oh);
    port_idx_t r;
    r = '0;
    for (int p = 0; p < PORTS; p++) begin
      if (oh[p]) r = port_idx_t'(p);
    end
    return r;
  endfunction

  function automatic port_vec_t port_onehot(input port_idx_t idx);
    return port_vec_t'(1) << idx;
  endfunction
endpackage

// File: rtl/sa_rr_arbiter.sv
module sa_rr_arbiter #(
  parameter int N  = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          advance,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx
);
  logic [IW-1:0] ptr;
  logic          found;
  logic          step;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    found   = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!found && req[(int'(ptr) + k) % N]) begin
        found   = 1'b1;
        gnt[(int'(ptr) + k) % N] = 1'b1;
        gnt_idx = IW'((int'(ptr) + k) % N);
      end
    end
  end

  assign step = advance && found;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (step) begin
      if (gnt_idx == IW'(N - 1)) ptr <= '0;
      else                       ptr <= gnt_idx + 1'b1;
    end
  end

  // pointer only moves on an accepted grant
  assert_ptr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(ptr));

  // a request always yields exactly one grant inside the request set
  assert_grant_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> ($onehot(gnt) && ((gnt & ~req) == '0)));
endmodule

// File: rtl/sa_route_select.sv
module sa_route_select
  import sa_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  port_vec_t route,
  input  port_vec_t congested,
  input  port_vec_t vc_free,
  input  logic      is_head,
  input  port_idx_t held_out,
  output port_vec_t target,
  output logic      valid
);
  port_vec_t uncongested;
  port_vec_t pool;
  port_vec_t head_pick;

  assign uncongested = route & ~congested;
  assign pool        = (|uncongested) ? uncongested : route;
  assign head_pick   = lowest_bit(pool & vc_free);
  assign target      = is_head ? head_pick : port_onehot(held_out);
  assign valid       = |target;

  // a head never picks a congested output while an uncongested one exists
  assert_avoid_congested_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_head && valid && (|(route & ~congested))) |-> ((target & congested) == '0));

  // a head only targets outputs whose own channel is free
  assert_head_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_head && valid) |-> ((target & ~vc_free) == '0));
endmodule

// File: rtl/sa_vc_owner.sv
module sa_vc_owner #(
  parameter int NUM_CH = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] claim,
  input  logic [NUM_CH-1:0] release_ch,
  output logic [NUM_CH-1:0] owned
);
  always_ff @(posedge clk) begin
    if (!rst_n) owned <= '0;
    else        owned <= (owned | claim) & ~release_ch;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    assert_claim_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (claim[c] && !release_ch[c]) |=> owned[c]);
    assert_release_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      release_ch[c] |=> !owned[c]);
    assert_no_double_claim_R2: assert property (@(posedge clk) disable iff (!rst_n)
      claim[c] |-> !owned[c]);
  end
endmodule

// File: rtl/switch_alloc_rvc.sv
module switch_alloc_rvc
  import sa_pkg::*;
#(
  parameter int NUM_VC = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [PORTS*NUM_VC-1:0]            req_valid,
  input  logic [PORTS*NUM_VC-1:0]            req_head,
  input  logic [PORTS*NUM_VC-1:0]            req_tail,
  input  logic [PORTS*NUM_VC*PORTS-1:0]      req_route,
  input  logic [PORTS*NUM_VC-1:0]            out_vc_idle,
  input  logic [PORTS-1:0]                   out_congested,
  output logic [PORTS-1:0]                   in_gnt,
  output logic [PORTS*$clog2(NUM_VC)-1:0]    in_gnt_vc,
  output logic [PORTS*PORT_IW-1:0]           in_gnt_out,
  output logic [PORTS*PORTS-1:0]             out_gnt,
  output logic [PORTS*NUM_VC-1:0]            vc_claim,
  output logic [PORTS*NUM_VC-1:0]            vc_release,
  output logic [PORTS*NUM_VC-1:0]            vc_owned
);
  localparam int VW = $clog2(NUM_VC);
  localparam int NK = PORTS * NUM_VC;

  port_vec_t   tgt      [NK];
  logic        tvalid   [NK];
  port_idx_t   held_q   [NK];
  logic [NUM_VC-1:0] req1  [PORTS];
  logic [NUM_VC-1:0] s1_gnt[PORTS];
  logic [VW-1:0]     s1_idx[PORTS];
  port_vec_t   in_tgt   [PORTS];
  logic        in_has   [PORTS];
  port_vec_t   req2     [PORTS];
  port_vec_t   out_g    [PORTS];
  port_idx_t   s2_idx   [PORTS];
  logic        out_busy [PORTS];
  port_idx_t   win_out  [PORTS];

  // ---------------- per input VC target selection ----------------
  for (genvar i = 0; i < PORTS; i++) begin : g_in
    for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
      localparam int K = i * NUM_VC + v;
      port_vec_t free_v;
      always_comb begin
        for (int o = 0; o < PORTS; o++) begin
          free_v[o] = out_vc_idle[o*NUM_VC+v] & ~vc_owned[o*NUM_VC+v];
        end
      end
      sa_route_select u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .route     (req_route[K*PORTS +: PORTS]),
        .congested (out_congested),
        .vc_free   (free_v),
        .is_head   (req_head[K]),
        .held_out  (held_q[K]),
        .target    (tgt[K]),
        .valid     (tvalid[K])
      );
      assign req1[i][v] = req_valid[K] & tvalid[K];
    end

    // first round: one VC per input
    sa_rr_arbiter #(.N(NUM_VC)) u_s1 (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req1[i]),
      .advance (in_gnt[i]),
      .gnt     (s1_gnt[i]),
      .gnt_idx (s1_idx[i])
    );

    assign in_tgt[i]  = tgt[i*NUM_VC + int'(s1_idx[i])];
    assign in_has[i]  = |req1[i];
    assign win_out[i] = port_index(in_tgt[i]);
    assign in_gnt_vc[i*VW +: VW]           = s1_idx[i];
    assign in_gnt_out[i*PORT_IW +: PORT_IW] = win_out[i];
  end

  // ---------------- second round: one input per output ----------------
  for (genvar o = 0; o < PORTS; o++) begin : g_out
    always_comb begin
      for (int i = 0; i < PORTS; i++) begin
        req2[o][i] = in_has[i] & in_tgt[i][o];
      end
    end
    assign out_busy[o] = |req2[o];
    sa_rr_arbiter #(.N(PORTS)) u_s2 (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req2[o]),
      .advance (out_busy[o]),
      .gnt     (out_g[o]),
      .gnt_idx (s2_idx[o])
    );
    assign out_gnt[o*PORTS +: PORTS] = out_g[o];
  end

  // input grant derived from the output winners' indices
  always_comb begin
    in_gnt = '0;
    for (int o = 0; o < PORTS; o++) begin
      if (out_busy[o]) in_gnt[s2_idx[o]] = 1'b1;
    end
  end

  // ---------------- VC claim / release after the output round ----------------
  always_comb begin
    vc_claim   = '0;
    vc_release = '0;
    for (int i = 0; i < PORTS; i++) begin
      if (in_gnt[i]) begin
        for (int o = 0; o < PORTS; o++) begin
          if (in_tgt[i][o]) begin
            if (req_head[i*NUM_VC + int'(s1_idx[i])])
              vc_claim[o*NUM_VC + int'(s1_idx[i])] = 1'b1;
            if (req_tail[i*NUM_VC + int'(s1_idx[i])])
              vc_release[o*NUM_VC + int'(s1_idx[i])] = 1'b1;
          end
        end
      end
    end
  end

  sa_vc_owner #(.NUM_CH(NK)) u_own (
    .clk        (clk),
    .rst_n      (rst_n),
    .claim      (vc_claim),
    .release_ch (vc_release),
    .owned      (vc_owned)
  );

  // held output per input VC, written when its head flit wins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NK; k++) held_q[k] <= '0;
    end else begin
      for (int i = 0; i < PORTS; i++) begin
        if (in_gnt[i] && req_head[i*NUM_VC + int'(s1_idx[i])])
          held_q[i*NUM_VC + int'(s1_idx[i])] <= win_out[i];
      end
    end
  end

  // output grants and input grants pair up one to one
  assert_grants_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_gnt) == $countones(in_gnt));

  // every head grant produces exactly one claim of its own channel
  assert_head_claims_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vc_claim) <= $countones(in_gnt));
endmodule

// File: tb/switch_alloc_rvc_tb.sv
module switch_alloc_rvc_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  req_valid, req_head, req_tail, out_vc_idle;
  logic [49:0] req_route;
  logic [4:0]  out_congested;
  logic [4:0]  in_gnt;
  logic [4:0]  in_gnt_vc;
  logic [14:0] in_gnt_out;
  logic [24:0] out_gnt;
  logic [9:0]  vc_claim, vc_release, vc_owned;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  switch_alloc_rvc #(.NUM_VC(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_head(req_head),
    .req_tail(req_tail), .req_route(req_route), .out_vc_idle(out_vc_idle),
    .out_congested(out_congested), .in_gnt(in_gnt), .in_gnt_vc(in_gnt_vc),
    .in_gnt_out(in_gnt_out), .out_gnt(out_gnt), .vc_claim(vc_claim),
    .vc_release(vc_release), .vc_owned(vc_owned)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    req_valid = '0; req_head = '0; req_tail = '0; req_route = '0;
    out_vc_idle = '1; out_congested = '0;
  endtask

  task automatic put(input int i, input int v, input bit h, input bit t, input logic [4:0] r);
    int k;
    k = i * 2 + v;
    req_valid[k] = 1'b1; req_head[k] = h; req_tail[k] = t;
    req_route[k*5 +: 5] = r;
  endtask

  task automatic do_reset();
    @(negedge clk);
    clear_in();
    rst_n = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic int out_of(input int i);
    return int'(in_gnt_out[i*3 +: 3]);
  endfunction

  task automatic t_reset();
    do_reset();
    #2;
    check("R1 owned after reset", int'(vc_owned), 0);
    check("R1 no grant idle", int'(in_gnt), 0);
    put(0, 0, 1, 0, 5'b00010); put(0, 1, 1, 0, 5'b00010); put(2, 0, 1, 0, 5'b00010);
    #2;
    check("R1 first input wins", int'(in_gnt), 1);
    check("R1 first vc wins", int'(in_gnt_vc[0]), 0);
    check("R1 out1 grant", int'(out_gnt[5 +: 5]), 1);
  endtask

  task automatic t_idle();
    do_reset();
    put(3, 1, 1, 0, 5'b00001);
    out_vc_idle[1] = 1'b0;
    #2;
    check("R2 busy downstream blocks", int'(in_gnt), 0);
    out_vc_idle = '1;
    #2;
    check("R2 idle downstream grants", int'(in_gnt), 5'b01000);
    check("R7 claim pulse (o0,v1)", int'(vc_claim), 10'b0000000010);
    @(posedge clk); #2;
    check("R7 owned after claim", int'(vc_owned[1]), 1);
    clear_in();
    put(4, 1, 1, 0, 5'b00001);
    put(4, 0, 1, 0, 5'b00001);
    #2;
    check("R2 owned channel blocked", int'(in_gnt_vc[4]), 0);
    check("R7 other vc claims own index", int'(vc_claim), 10'b0000000001);
  endtask

  task automatic t_cong();
    do_reset();
    put(1, 0, 1, 0, 5'b01010);
    out_congested = 5'b00010;
    #2;
    check("R3 congested masked", out_of(1), 3);
    out_congested = 5'b01010;
    #2;
    check("R3 all congested fallback", out_of(1), 1);
    out_congested = 5'b00000;
    #2;
    check("R3 lowest candidate", out_of(1), 1);
    out_vc_idle[2] = 1'b0;
    #2;
    check("R3 skip busy channel", out_of(1), 3);
  endtask

  task automatic t_rr_vc();
    do_reset();
    put(0, 0, 1, 1, 5'b00100); put(0, 1, 1, 1, 5'b00100);
    for (int n = 0; n < 3; n++) begin
      #2;
      check("R4 vc rotation", int'(in_gnt_vc[0]), n % 2);
      @(posedge clk); #2;
      check("R8 single-flit leaves free", int'(vc_owned), 0);
    end
  endtask

  task automatic t_rr_in();
    int exp_w[4] = '{0, 1, 4, 0};
    do_reset();
    put(0, 0, 1, 1, 5'b00100); put(1, 0, 1, 1, 5'b00100); put(4, 0, 1, 1, 5'b00100);
    for (int n = 0; n < 4; n++) begin
      #2;
      check("R5 input rotation", int'(out_gnt[10 +: 5]), 1 << exp_w[n]);
      check("R6 one grant per output", $countones(in_gnt), 1);
      @(posedge clk);
    end
  endtask

  task automatic t_release();
    do_reset();
    put(2, 1, 1, 0, 5'b10000);
    @(posedge clk); #2;
    check("R7 head owns (o4,v1)", int'(vc_owned[9]), 1);
    put(2, 1, 0, 0, 5'b00000);
    @(posedge clk); #2;
    check("R8 body keeps ownership", int'(vc_owned[9]), 1);
    put(2, 1, 0, 1, 5'b00000);
    #2;
    check("R8 tail release pulse", int'(vc_release[9]), 1);
    @(posedge clk); #2;
    check("R8 tail frees channel", int'(vc_owned[9]), 0);
  endtask

  task automatic t_body();
    do_reset();
    put(2, 0, 1, 0, 5'b01000);
    @(posedge clk); #2;
    check("R7 head owns (o3,v0)", int'(vc_owned[6]), 1);
    put(2, 0, 0, 0, 5'b00001);
    out_congested = 5'b01000;
    out_vc_idle[6] = 1'b0;
    #2;
    check("R9 body granted", int'(in_gnt[2]), 1);
    check("R9 body uses held output", out_of(2), 3);
  endtask

  task automatic t_hold();
    do_reset();
    put(0, 0, 1, 1, 5'b00001);
    put(1, 0, 1, 1, 5'b00001);
    put(1, 1, 1, 1, 5'b00100);
    #2;
    check("R10 input1 loses at output", int'(in_gnt), 1);
    @(posedge clk); #2;
    req_valid[0] = 1'b0;
    #2;
    check("R10 input1 granted", int'(in_gnt[1]), 1);
    check("R10 pointer held on loss", int'(in_gnt_vc[1]), 0);
  endtask

  initial begin
    clear_in();
    rst_n = 1'b0;
    t_reset();
    t_idle();
    t_cong();
    t_rr_vc();
    t_rr_in();
    t_release();
    t_body();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule